// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block is the host side of a two-wire debug link made of one clock line and one bidirectional data line. It accepts one command at a time over a valid/ready handshake. For each command it produces the complete bit-level frame on the link: a START strobe, a 2-bit instruction sent LSB first, a LENGTH field where the command needs one, eight address or data bits, a WAIT handshake for data commands, and a closing STOP strobe. Each bit is clocked by a strobe of the form high-low-high. The length of the low pulse is bounded, because the target treats a long low pulse as a reset request. A separate command produces that long pulse on purpose.

When the command has finished, the block returns the captured byte and a timeout flag along with a one-cycle done pulse. The strobe timing comes from counting system-clock ticks. The low-pulse length, the post-strobe high time and the reset-hold length are parameters, as is the maximum number of WAIT strobes.

The controller is one state machine with these states:
- ST_IDLE: waiting for a command.
- ST_START: the START strobe.
- ST_INSTR: the instruction bits.
- ST_LEN: the length bits.
- ST_TXBITS: eight bits driven to the target.
- ST_RXBITS: eight bits sampled from the target.
- ST_WAIT: the handshake strobes.
- ST_STOP: the closing STOP strobe.
- ST_RSTHOLD: the long reset pulse.
- ST_DONE: the result cycle.

Every transition except two happens on the last cycle of a strobe:
- ST_IDLE moves to ST_START on an accepted frame command, or to ST_RSTHOLD on an accepted reset command.
- ST_START moves to ST_INSTR.
- ST_INSTR goes next to ST_TXBITS for an address write, to ST_RXBITS for an address read, and to ST_LEN for a data command.
- ST_LEN moves to ST_TXBITS for a data write and to ST_WAIT for a data read.
- ST_TXBITS moves to ST_STOP for an address write and to ST_WAIT for a data write.
- ST_WAIT moves to ST_STOP (data write) or ST_RXBITS (data read) once data was seen high. It moves to ST_DONE when the handshake times out, and otherwise it strobes again.
- ST_RXBITS and ST_STOP lead toward ST_DONE: ST_RXBITS moves to ST_STOP, and ST_STOP moves to ST_DONE.
- ST_RSTHOLD moves to ST_DONE.
- ST_DONE returns unconditionally to ST_IDLE one cycle later.

Top module: `dbg2w_master`

## Requirements
- R1: While `link_en` is low, `lnk_clk_oe`, `lnk_dat_oe` and `cmd_ready` are low, and a command held on `cmd_valid` starts nothing. `lnk_clk_oe` follows `link_en`. `lnk_clk_o` is already high in the cycle the clock output is enabled, and the data line is an input at that point.
- R2: `cmd_ready` is high only when the block is idle and the link is enabled. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high from the cycle after acceptance through the cycle with the one-cycle `done` pulse. `rsp_byte` and `rsp_timeout` are valid in the done cycle and hold until the next command is accepted.
- R3: Each ordinary strobe drives `lnk_clk_o` low for LOW_TICKS cycles and then high for HIGH_TICKS cycles. Strobes follow each other back to back. The first low cycle is the cycle after acceptance. Outside a strobe the clock stays high, and no low run in a frame command ever exceeds LOW_TICKS.
- R4: Every frame opens with one START strobe with the data line released. The data line is then driven with the 2-bit instruction, LSB first: 11 for address write, 10 for address read, 01 for data write, 00 for data read. `lnk_dat_o` is 0 whenever `lnk_dat_oe` is 0.
- R5: An address write (`cmd_op` = 0) drives `cmd_byte` LSB first, one bit per strobe. The data line is then released for a single STOP strobe, giving 12 strobes in total. The returned byte is 0.
- R6: An address read (`cmd_op` = 1) releases the data line after the instruction. It samples 8 bits LSB first, ends with STOP, and returns the sampled byte.
- R7: Both data commands drive a 2-bit LENGTH field of 00 right after the instruction.
- R8: A data write (`cmd_op` = 2) drives `cmd_byte` LSB first after LENGTH, then performs WAIT, then STOP. The returned byte is 0.
- R9: A data read (`cmd_op` = 3) performs WAIT right after LENGTH. It then samples 8 bits LSB first, ends with STOP, and returns the byte.
- R10: In WAIT the data line is released and strobes repeat until a strobe samples data high. A high sample on the WAIT_MAX-th strobe still succeeds. If WAIT_MAX strobes all sample low, the command ends with no STOP strobe, `rsp_timeout` = 1 and `rsp_byte` = 0.
- R11: Any `cmd_op` with bit 2 set is a target reset. It holds the clock low for RST_TICKS cycles and then high for HIGH_TICKS cycles, never drives data, and then signals done with no timeout.
- R12: Input data is sampled at the end of the first system-clock cycle of each strobe in which `lnk_clk_o` is high. A value on `lnk_dat_i` at any other time in the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Link access on |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | 0 addr write, 1 addr read, 2 data write, 3 data read, 4-7 target reset |
| cmd_byte | input | DATA_W | Address or data byte to send |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_byte | output | DATA_W | Captured byte |
| rsp_timeout | output | 1 | WAIT handshake expired |
| lnk_clk_o | output | 1 | Link clock level |
| lnk_clk_oe | output | 1 | Link clock output enable |
| lnk_dat_o | output | 1 | Link data level driven |
| lnk_dat_oe | output | 1 | Link data output enable |
| lnk_dat_i | input | 1 | Link data level seen |

## Verification
The assertions check several properties on every cycle:
- the link stays silent while it is disabled;
- the clock is already high when its output is enabled;
- the clock is high whenever the block is idle;
- the handshake, busy and done pulse keep their ordering;
- no ordinary low pulse grows longer than LOW_TICKS;
- a reset pulse is never longer than RST_TICKS;
- the data line is never driven during a reset command;
- a timed-out result carries a zero byte.

Only the bench scenarios can show that each frame has the right strobe count, field order, instruction and length codes and bit order. They also show that the WAIT handshake ends at exactly the right strobe, including the last-allowed strobe and the timeout case. Finally, they show that read bytes come from the single sampling cycle: the bench drives the opposite value on the data input in every other cycle of each read strobe.

// File: rtl/dbg2w_pkg.sv
`timescale 1ns/1ps
package dbg2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_INSTR,
        ST_LEN,
        ST_TXBITS,
        ST_RXBITS,
        ST_WAIT,
        ST_STOP,
        ST_RSTHOLD,
        ST_DONE
    } fsm_state_t;

    typedef enum logic [2:0] {
        OP_ADDR_WR = 3'd0,
        OP_ADDR_RD = 3'd1,
        OP_DATA_WR = 3'd2,
        OP_DATA_RD = 3'd3,
        OP_TGT_RST = 3'd4
    } op_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_t;

    // Any code with the top bit set selects a target reset.
    function automatic op_t decode_op(input logic [2:0] raw);
        if (raw[2]) return OP_TGT_RST;
        return op_t'(raw);
    endfunction

    // Instruction field value, shifted out LSB first.
    function automatic logic [1:0] instr_code(input op_t op);
        case (op)
            OP_ADDR_WR: return 2'b11;
            OP_ADDR_RD: return 2'b10;
            OP_DATA_WR: return 2'b01;
            default:    return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/dbg2w_strobe_timer.sv
`timescale 1ns/1ps
module dbg2w_strobe_timer
    import dbg2w_pkg::*;
#(
    parameter int LOW_TICKS  = 250,
    parameter int HIGH_TICKS = 250,
    parameter int HOLD_TICKS = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic go_long,
    output logic clk_low,
    output logic sample_now,
    output logic strobe_end
);
    localparam int MAX_LH = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
    localparam int MAX_T  = (HOLD_TICKS > MAX_LH) ? HOLD_TICKS : MAX_LH;
    localparam int CW     = $clog2(MAX_T + 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          long_sel;
    logic          low_last;
    logic          high_last;

    assign low_last   = long_sel ? (cnt == CW'(HOLD_TICKS - 1)) : (cnt == CW'(LOW_TICKS - 1));
    assign high_last  = (cnt == CW'(HIGH_TICKS - 1));
    assign clk_low    = (phase == PH_LOW);
    assign sample_now = (phase == PH_HIGH) && (cnt == '0);
    assign strobe_end = (phase == PH_HIGH) && high_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            long_sel <= 1'b0;
        end else if (go) begin
            phase    <= PH_LOW;
            cnt      <= '0;
            long_sel <= go_long;
        end else begin
            unique case (phase)
                PH_LOW: begin
                    if (low_last) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (high_last) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/dbg2w_shifter.sv
`timescale 1ns/1ps
module dbg2w_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_tx,
    input  logic         shift_rx,
    input  logic         rx_bit,
    output logic [W-1:0] q,
    output logic         lsb
);
    assign lsb = q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_rx) begin
            q <= {rx_bit, q[W-1:1]};
        end else if (shift_tx) begin
            q <= {1'b0, q[W-1:1]};
        end
    end

endmodule

// File: rtl/dbg2w_master.sv
`timescale 1ns/1ps
module dbg2w_master
    import dbg2w_pkg::*;
#(
    parameter int LOW_TICKS  = 250,
    parameter int HIGH_TICKS = 250,
    parameter int RST_TICKS  = 6250,
    parameter int WAIT_MAX   = 20,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_byte,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rsp_byte,
    output logic              rsp_timeout,
    output logic              lnk_clk_o,
    output logic              lnk_clk_oe,
    output logic              lnk_dat_o,
    output logic              lnk_dat_oe,
    input  logic              lnk_dat_i
);
    localparam int BCW = $clog2(DATA_W);
    localparam int WCW = $clog2(WAIT_MAX + 1);

    fsm_state_t     state, state_d;
    op_t            op_q;
    logic [BCW-1:0] bit_cnt;
    logic [WCW-1:0] wait_cnt;
    logic           wait_hit;
    logic           to_q;

    logic accept;
    logic go, go_long;
    logic bit_clr, bit_inc, wait_inc, to_set;
    logic clk_low, sample_now, strb_end;
    logic tx_lsb;
    logic is_write;
    op_t  op_in;

    assign op_in    = decode_op(cmd_op);
    assign accept   = cmd_valid && cmd_ready;
    assign is_write = (op_in == OP_ADDR_WR) || (op_in == OP_DATA_WR);

    dbg2w_strobe_timer #(
        .LOW_TICKS (LOW_TICKS),
        .HIGH_TICKS(HIGH_TICKS),
        .HOLD_TICKS(RST_TICKS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_long   (go_long),
        .clk_low   (clk_low),
        .sample_now(sample_now),
        .strobe_end(strb_end)
    );

    dbg2w_shifter #(.W(DATA_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (to_set),
        .load    (accept),
        .load_val(is_write ? cmd_byte : '0),
        .shift_tx(strb_end && (state == ST_TXBITS)),
        .shift_rx(sample_now && (state == ST_RXBITS)),
        .rx_bit  (lnk_dat_i),
        .q       (rsp_byte),
        .lsb     (tx_lsb)
    );

    // Next-state and control decode
    always_comb begin
        state_d  = state;
        go       = 1'b0;
        go_long  = 1'b0;
        bit_clr  = 1'b0;
        bit_inc  = 1'b0;
        wait_inc = 1'b0;
        to_set   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    go = 1'b1;
                    if (op_in == OP_TGT_RST) begin
                        state_d = ST_RSTHOLD;
                        go_long = 1'b1;
                    end else begin
                        state_d = ST_START;
                    end
                end
            end
            ST_START: begin
                if (strb_end) begin
                    state_d = ST_INSTR;
                    go      = 1'b1;
                    bit_clr = 1'b1;
                end
            end
            ST_INSTR: begin
                if (strb_end) begin
                    go = 1'b1;
                    if (bit_cnt == BCW'(1)) begin
                        bit_clr = 1'b1;
                        unique case (op_q)
                            OP_ADDR_WR: state_d = ST_TXBITS;
                            OP_ADDR_RD: state_d = ST_RXBITS;
                            default:    state_d = ST_LEN;
                        endcase
                    end else begin
                        bit_inc = 1'b1;
                    end
                end
            end
            ST_LEN: begin
                if (strb_end) begin
                    go = 1'b1;
                    if (bit_cnt == BCW'(1)) begin
                        bit_clr = 1'b1;
                        state_d = (op_q == OP_DATA_WR) ? ST_TXBITS : ST_WAIT;
                    end else begin
                        bit_inc = 1'b1;
                    end
                end
            end
            ST_TXBITS: begin
                if (strb_end) begin
                    go = 1'b1;
                    if (bit_cnt == BCW'(DATA_W - 1)) begin
                        bit_clr = 1'b1;
                        state_d = (op_q == OP_ADDR_WR) ? ST_STOP : ST_WAIT;
                    end else begin
                        bit_inc = 1'b1;
                    end
                end
            end
            ST_RXBITS: begin
                if (strb_end) begin
                    go = 1'b1;
                    if (bit_cnt == BCW'(DATA_W - 1)) begin
                        bit_clr = 1'b1;
                        state_d = ST_STOP;
                    end else begin
                        bit_inc = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (strb_end) begin
                    if (wait_hit) begin
                        go      = 1'b1;
                        bit_clr = 1'b1;
                        state_d = (op_q == OP_DATA_WR) ? ST_STOP : ST_RXBITS;
                    end else if (wait_cnt == WCW'(WAIT_MAX - 1)) begin
                        to_set  = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        go       = 1'b1;
                        wait_inc = 1'b1;
                    end
                end
            end
            ST_STOP, ST_RSTHOLD: begin
                if (strb_end) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_ADDR_WR;
            bit_cnt  <= '0;
            wait_cnt <= '0;
            wait_hit <= 1'b0;
            to_q     <= 1'b0;
        end else begin
            state <= state_d;
            if (accept) begin
                op_q     <= op_in;
                bit_cnt  <= '0;
                wait_cnt <= '0;
                to_q     <= 1'b0;
            end else begin
                if (bit_clr)       bit_cnt  <= '0;
                else if (bit_inc)  bit_cnt  <= bit_cnt + 1'b1;
                if (wait_inc)      wait_cnt <= wait_cnt + 1'b1;
                if (to_set)        to_q     <= 1'b1;
            end
            if (go)
                wait_hit <= 1'b0;
            else if (sample_now && (state == ST_WAIT) && lnk_dat_i)
                wait_hit <= 1'b1;
        end
    end

    // Output decode
    always_comb begin
        logic oe;
        logic bit_v;
        logic [1:0] code;
        code  = instr_code(op_q);
        oe    = 1'b0;
        bit_v = 1'b0;
        unique case (state)
            ST_INSTR: begin
                oe    = 1'b1;
                bit_v = code[bit_cnt[0]];
            end
            ST_LEN: begin
                oe    = 1'b1;
                bit_v = 1'b0;
            end
            ST_TXBITS: begin
                oe    = 1'b1;
                bit_v = tx_lsb;
            end
            default: begin
                oe    = 1'b0;
                bit_v = 1'b0;
            end
        endcase
        lnk_dat_oe  = oe && link_en;
        lnk_dat_o   = oe && link_en && bit_v;
        lnk_clk_o   = !clk_low;
        lnk_clk_oe  = link_en;
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        cmd_ready   = (state == ST_IDLE) && link_en;
        rsp_timeout = to_q;
    end

endmodule

// File: rtl/dbg2w_master_chk.sv
`timescale 1ns/1ps
module dbg2w_master_chk #(
    parameter int LOW_TICKS = 250,
    parameter int RST_TICKS = 6250,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_en,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rsp_byte,
    input logic              rsp_timeout,
    input logic              lnk_clk_o,
    input logic              lnk_clk_oe,
    input logic              lnk_dat_o,
    input logic              lnk_dat_oe
);
    int unsigned low_run;
    logic        rst_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= 0;
            rst_frame <= 1'b0;
        end else begin
            if (lnk_clk_o)                     low_run <= 0;
            else if (low_run <= RST_TICKS)     low_run <= low_run + 1;
            if (cmd_valid && cmd_ready)        rst_frame <= cmd_op[2];
        end
    end

    AST_LINK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |-> (!lnk_clk_oe && !lnk_dat_oe && !cmd_ready)); // R1
    AST_CLK_HIGH_AT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_clk_oe) |-> (lnk_clk_o && !lnk_dat_oe)); // R1
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!busy && lnk_clk_o)); // R2
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (busy && !done)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R2
    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> lnk_clk_o); // R3
    AST_LOW_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!lnk_clk_o && !rst_frame) |-> (low_run < LOW_TICKS)); // R3
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_dat_oe |-> !lnk_dat_o); // R4
    AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_timeout) |-> (rsp_byte == '0)); // R10
    AST_RST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_clk_o |-> (low_run < RST_TICKS)); // R11
    AST_RST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_frame && busy) |-> !lnk_dat_oe); // R11

endmodule

bind dbg2w_master dbg2w_master_chk #(
    .LOW_TICKS(LOW_TICKS),
    .RST_TICKS(RST_TICKS),
    .DATA_W   (DATA_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_en    (link_en),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .busy       (busy),
    .done       (done),
    .rsp_byte   (rsp_byte),
    .rsp_timeout(rsp_timeout),
    .lnk_clk_o  (lnk_clk_o),
    .lnk_clk_oe (lnk_clk_oe),
    .lnk_dat_o  (lnk_dat_o),
    .lnk_dat_oe (lnk_dat_oe)
);

// File: tb/test_dbg2w_master.sv
`timescale 1ns/1ps
module test_dbg2w_master;
    localparam int LO = 3;
    localparam int HI = 3;
    localparam int RT = 14;
    localparam int WM = 20;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_en = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_byte = 8'd0;
    logic       busy, done;
    logic [7:0] rsp_byte;
    logic       rsp_timeout;
    logic       lnk_clk_o, lnk_clk_oe, lnk_dat_o, lnk_dat_oe;
    logic       lnk_dat_i = 1'b0;

    always #2 clk = ~clk;

    dbg2w_master #(
        .LOW_TICKS(LO), .HIGH_TICKS(HI), .RST_TICKS(RT), .WAIT_MAX(WM), .DATA_W(8)
    ) i_dbg2w_master (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .busy(busy), .done(done), .rsp_byte(rsp_byte), .rsp_timeout(rsp_timeout),
        .lnk_clk_o(lnk_clk_o), .lnk_clk_oe(lnk_clk_oe),
        .lnk_dat_o(lnk_dat_o), .lnk_dat_oe(lnk_dat_oe), .lnk_dat_i(lnk_dat_i)
    );

    // Entry: {clk, oe, dout, din_drive, busy, done}
    logic [5:0] exp_q[$];
    logic [5:0] pend_q[$];
    logic [7:0] exp_rsp;
    logic       exp_to;
    string      cur_tag = "R1";
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cyc = 0;
    bit         run_cmp = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Reference model: one expected entry per clock, compared mid-cycle
    always @(negedge clk) begin
        if (run_cmp) begin
            logic [5:0] e;
            logic [5:0] a;
            cyc++;
            if (cyc > WATCHDOG) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
                finish_run();
            end
            if (exp_q.size() != 0) e = exp_q.pop_front();
            else                   e = 6'b100000;
            lnk_dat_i = e[2];
            a = {lnk_clk_o, lnk_dat_oe, lnk_dat_o, e[2], busy, done};
            chk(cur_tag, "link/busy/done per cycle (R3 clock shape)", {26'd0, a}, {26'd0, e});
            chk("R1", "clk_oe follows link_en", {31'd0, lnk_clk_oe}, {31'd0, link_en});
            if (e[0]) begin
                chk(cur_tag, "rsp_byte at done", {24'd0, rsp_byte}, {24'd0, exp_rsp});
                chk(cur_tag, "rsp_timeout at done (R10)", {31'd0, rsp_timeout}, {31'd0, exp_to});
            end
        end
    end

    task automatic push_strobe(input logic oe, input logic dout, input bit smp, input logic din_bit, input int low_len);
        for (int i = 0; i < low_len; i++)
            pend_q.push_back({1'b0, oe, dout, smp ? ~din_bit : 1'b0, 1'b1, 1'b0});
        for (int i = 0; i < HI; i++)
            pend_q.push_back({1'b1, oe, dout, smp ? ((i == 0) ? din_bit : ~din_bit) : 1'b0, 1'b1, 1'b0});
    endtask

    task automatic push_done();
        pend_q.push_back(6'b100011);
    endtask

    task automatic push_prefix(input logic [1:0] code);
        push_strobe(1'b0, 1'b0, 0, 1'b0, LO);          // START, released
        push_strobe(1'b1, code[0], 0, 1'b0, LO);
        push_strobe(1'b1, code[1], 0, 1'b0, LO);
    endtask

    task automatic push_len();
        push_strobe(1'b1, 1'b0, 0, 1'b0, LO);
        push_strobe(1'b1, 1'b0, 0, 1'b0, LO);
    endtask

    // Returns 1 when the handshake expires
    task automatic push_wait(input int w, output bit expired);
        int n;
        n = (w < WM) ? w : WM;
        for (int i = 0; i < n; i++) push_strobe(1'b0, 1'b0, 1, 1'b0, LO);
        if (w < WM) push_strobe(1'b0, 1'b0, 1, 1'b1, LO);
        expired = (w >= WM);
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] b, input string tag);
        @(negedge clk); #1;
        chk("R2", "cmd_ready before issue", {31'd0, cmd_ready}, 32'd1);
        cur_tag   = tag;
        cmd_op    = op;
        cmd_byte  = b;
        cmd_valid = 1'b1;
        exp_q     = pend_q;
        pend_q.delete();
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        cmd_byte  = 8'h00;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
        chk("R2", "rsp_byte held after done", {24'd0, rsp_byte}, {24'd0, exp_rsp});
        chk("R2", "rsp_timeout held after done", {31'd0, rsp_timeout}, {31'd0, exp_to});
    endtask

    task automatic do_addr_wr(input logic [7:0] b);
        push_prefix(2'b11);
        for (int i = 0; i < 8; i++) push_strobe(1'b1, b[i], 0, 1'b0, LO);
        push_strobe(1'b0, 1'b0, 0, 1'b0, LO);
        push_done();
        exp_rsp = 8'h00; exp_to = 1'b0;
        issue(3'd0, b, "R5 R4");
    endtask

    task automatic do_addr_rd(input logic [7:0] tgt);
        push_prefix(2'b10);
        for (int i = 0; i < 8; i++) push_strobe(1'b0, 1'b0, 1, tgt[i], LO);
        push_strobe(1'b0, 1'b0, 0, 1'b0, LO);
        push_done();
        exp_rsp = tgt; exp_to = 1'b0;
        issue(3'd1, 8'hFF, "R6 R12");
    endtask

    task automatic do_data_wr(input logic [7:0] b, input int w);
        bit ex;
        push_prefix(2'b01);
        push_len();
        for (int i = 0; i < 8; i++) push_strobe(1'b1, b[i], 0, 1'b0, LO);
        push_wait(w, ex);
        if (!ex) push_strobe(1'b0, 1'b0, 0, 1'b0, LO);
        push_done();
        exp_rsp = 8'h00; exp_to = ex;
        issue(3'd2, b, ex ? "R10" : "R8 R7");
    endtask

    task automatic do_data_rd(input logic [7:0] tgt, input int w);
        bit ex;
        push_prefix(2'b00);
        push_len();
        push_wait(w, ex);
        if (!ex) begin
            for (int i = 0; i < 8; i++) push_strobe(1'b0, 1'b0, 1, tgt[i], LO);
            push_strobe(1'b0, 1'b0, 0, 1'b0, LO);
        end
        push_done();
        exp_rsp = ex ? 8'h00 : tgt; exp_to = ex;
        issue(3'd3, 8'h00, ex ? "R10" : "R9 R12");
    endtask

    task automatic do_reset(input logic [2:0] op);
        push_strobe(1'b0, 1'b0, 0, 1'b0, RT);
        push_done();
        exp_rsp = 8'h00; exp_to = 1'b0;
        issue(op, 8'h5A, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "clk_oe in reset", {31'd0, lnk_clk_oe}, 32'd0);
        chk("R1", "dat_oe in reset", {31'd0, lnk_dat_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R2", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R2", "ready with link off", {31'd0, cmd_ready}, 32'd0);
        chk("R3", "clock idles high", {31'd0, lnk_clk_o}, 32'd1);
        chk("R2", "rsp after reset", {23'd0, rsp_timeout, rsp_byte}, 32'd0);
        run_cmp = 1;

        // R1: a command offered while the link is off starts nothing
        cur_tag = "R1";
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_byte = 8'hA5;
        repeat (6) @(negedge clk);
        #1;
        chk("R1", "ready while link off", {31'd0, cmd_ready}, 32'd0);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        link_en = 1'b1;
        @(negedge clk); #1;
        chk("R1", "clock high when enabled", {30'd0, lnk_clk_o, lnk_dat_oe}, 32'd2);

        do_addr_wr(8'hA5);
        do_addr_wr(8'h01);
        do_addr_rd(8'h3C);
        do_addr_rd(8'hFF);
        do_data_wr(8'h96, 0);
        do_data_wr(8'h5A, 3);
        do_data_rd(8'hC3, 2);
        do_data_rd(8'h80, 0);
        do_data_rd(8'h6E, WM - 1);  // R10 boundary: last allowed strobe
        do_data_rd(8'h6E, WM);      // R10 timeout on read
        do_data_wr(8'h11, WM);      // R10 timeout on write
        do_addr_rd(8'h01);          // R2 timeout flag cleared by next command
        do_reset(3'd4);
        do_reset(3'd7);
        do_data_rd(8'h2D, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule